// File: doc/BRIEF.md
# Dual-Port QoS Request Merger with Least-Recently-Granted Tie Order

This block joins two requestor ports onto a single downstream memory port. Read-address and write-address requests pass through two separate merging channels that share nothing but the clock and reset. Each request comes with a 4-bit unsigned QoS value. The request with the larger QoS takes the downstream port. When both QoS values are the same, the port that was served less recently goes first. When four sources need a path to memory, two instances of the block are used, each serving a pair of sources.

Each channel uses the same valid/ready handshake on both sides. Once a request is offered downstream, it stays on the port until the downstream side accepts it. The forwarded request carries the winning port's index so that the response path can route the reply back to that port. The block has no data channels, no response handling and no buffering.

Top module: `qos_pair_merger`

## Requirements
- R1: While no request is pending, the channel's outValid is low and both reqReady bits are low. The first tie after reset goes to port 0.
- R2: When both ports are pending and no grant is held, the port with the numerically larger 4-bit unsigned QoS is forwarded.
- R3: When both ports are pending with equal QoS and no grant is held, the port that was served less recently is forwarded.
- R4: When both ports request continuously at equal QoS and outReady stays high, the forwarded port index alternates every cycle.
- R5: A lone pending request is forwarded in the same cycle, whatever its QoS.
- R6: While outReady is low and the forwarded request stays valid, the same port stays forwarded, even if the other port raises a higher QoS.
- R7: The tie order changes only on a completed downstream handshake (outValid and outReady both high). A grant that is stalled or withdrawn leaves the tie order unchanged.
- R8: outAddr and outQos are the forwarded port's values, and outPort is that port's index (0 or 1). reqReady is high for at most one port, only for the forwarded port, and only while outReady is high.
- R9: The read channel and the write channel are arbitrated independently: traffic on one never changes the grant or the tie order of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReqValid | input | 2 | Read request valid, one bit per port |
| rdReqReady | output | 2 | Read request accepted, one bit per port |
| rdReqQos | input | 2x4 | Read QoS per port |
| rdReqAddr | input | 2xADDR_W | Read address per port |
| rdOutValid | output | 1 | Forwarded read request valid |
| rdOutReady | input | 1 | Downstream accepts the read request |
| rdOutAddr | output | ADDR_W | Forwarded read address |
| rdOutQos | output | 4 | Forwarded read QoS |
| rdOutPort | output | 1 | Index of the forwarded read port |
| wrReqValid | input | 2 | Write request valid, one bit per port |
| wrReqReady | output | 2 | Write request accepted, one bit per port |
| wrReqQos | input | 2x4 | Write QoS per port |
| wrReqAddr | input | 2xADDR_W | Write address per port |
| wrOutValid | output | 1 | Forwarded write request valid |
| wrOutReady | input | 1 | Downstream accepts the write request |
| wrOutAddr | output | ADDR_W | Forwarded write address |
| wrOutQos | output | 4 | Forwarded write QoS |
| wrOutPort | output | 1 | Index of the forwarded write port |

## Verification
The hardest case to reach is a stalled grant that meets a later request from the other port with higher QoS. A second hard case is a grant that is offered but never accepted, where the tie order must stay unchanged. Random stimulus only gets close to these by chance. Directed sequences therefore hold outReady low across several cycles while the other port arrives with QoS 15, and in another sequence withdraw a stalled request before a tie. Random traffic keeps every stalled request stable, biases QoS toward small values so that ties are common, and throttles outReady on both channels at once.

// File: rtl/qarb_pkg.sv
`timescale 1ns/1ps
package qarb_pkg;
  localparam int NUM_PORTS = 2;
  localparam int NUM_CHANS = 2;

  typedef struct packed {
    logic fwdValid;
    logic selPort;
    logic fire;
  } arb_strobe_t;
endpackage

// File: rtl/qarb_ctrl.sv
`timescale 1ns/1ps
module qarb_ctrl
  import qarb_pkg::*;
#(
  parameter int QOS_W = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_PORTS-1:0]            reqValid,
  input  logic [NUM_PORTS-1:0][QOS_W-1:0] reqQos,
  input  logic                            outReady,
  output arb_strobe_t                     strb
);
  logic lrgQ;
  logic heldQ;
  logic heldPortQ;
  logic heldEff;
  logic pick;
  logic bothEq;

  always_comb begin
    heldEff = heldQ && reqValid[heldPortQ];
    bothEq  = (&reqValid) && (reqQos[0] == reqQos[1]);
    pick    = 1'b0;
    if (heldEff) begin
      pick = heldPortQ;
    end else if (reqValid == 2'b10) begin
      pick = 1'b1;
    end else if (reqValid == 2'b11) begin
      if (reqQos[1] > reqQos[0])      pick = 1'b1;
      else if (reqQos[0] > reqQos[1]) pick = 1'b0;
      else                            pick = lrgQ;
    end
    strb.fwdValid = |reqValid;
    strb.selPort  = pick;
    strb.fire     = (|reqValid) && outReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lrgQ      <= 1'b0;
      heldQ     <= 1'b0;
      heldPortQ <= 1'b0;
    end else if (strb.fire) begin
      lrgQ  <= ~strb.selPort;
      heldQ <= 1'b0;
    end else if (strb.fwdValid) begin
      heldQ     <= 1'b1;
      heldPortQ <= strb.selPort;
    end else begin
      heldQ <= 1'b0;
    end
  end

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fwdValid && !outReady) |=>
      (!reqValid[$past(strb.selPort)] || strb.selPort == $past(strb.selPort)));

  // R7
  lrg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.fire) |=> $stable(lrgQ));

  // R4
  alternate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && bothEq) |=> (!bothEq || strb.selPort != $past(strb.selPort)));

  // R5
  lone_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid == 2'b01 || reqValid == 2'b10) |->
      (strb.fwdValid && reqValid[strb.selPort]));

  // R2
  qos_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((&reqValid) && !heldEff && reqQos[0] != reqQos[1]) |->
      (reqQos[strb.selPort] > reqQos[~strb.selPort]));
endmodule

// File: rtl/qarb_datapath.sv
`timescale 1ns/1ps
module qarb_datapath
  import qarb_pkg::*;
#(
  parameter int QOS_W  = 4,
  parameter int ADDR_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  arb_strobe_t                      strb,
  input  logic [NUM_PORTS-1:0]             reqValid,
  input  logic [NUM_PORTS-1:0][QOS_W-1:0]  reqQos,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] reqAddr,
  output logic [NUM_PORTS-1:0]             reqReady,
  output logic                             outValid,
  output logic [ADDR_W-1:0]                outAddr,
  output logic [QOS_W-1:0]                 outQos,
  output logic                             outPort
);
  assign outValid = strb.fwdValid;
  assign outAddr  = reqAddr[strb.selPort];
  assign outQos   = reqQos[strb.selPort];
  assign outPort  = strb.selPort;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ready
    assign reqReady[p] = strb.fire && (strb.selPort == 1'(p));

    // R8
    ready_route_chk: assert property (@(posedge clk) disable iff (!rstN)
      reqReady[p] |-> (reqValid[p] && outValid && outPort == 1'(p)));
  end

  // R8
  ready_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqReady));
endmodule

// File: rtl/qos_pair_merger.sv
`timescale 1ns/1ps
module qos_pair_merger
  import qarb_pkg::*;
#(
  parameter int QOS_W  = 4,
  parameter int ADDR_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_PORTS-1:0]             rdReqValid,
  output logic [NUM_PORTS-1:0]             rdReqReady,
  input  logic [NUM_PORTS-1:0][QOS_W-1:0]  rdReqQos,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] rdReqAddr,
  output logic                             rdOutValid,
  input  logic                             rdOutReady,
  output logic [ADDR_W-1:0]                rdOutAddr,
  output logic [QOS_W-1:0]                 rdOutQos,
  output logic                             rdOutPort,
  input  logic [NUM_PORTS-1:0]             wrReqValid,
  output logic [NUM_PORTS-1:0]             wrReqReady,
  input  logic [NUM_PORTS-1:0][QOS_W-1:0]  wrReqQos,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] wrReqAddr,
  output logic                             wrOutValid,
  input  logic                             wrOutReady,
  output logic [ADDR_W-1:0]                wrOutAddr,
  output logic [QOS_W-1:0]                 wrOutQos,
  output logic                             wrOutPort
);
  logic [NUM_CHANS-1:0][NUM_PORTS-1:0]             validA;
  logic [NUM_CHANS-1:0][NUM_PORTS-1:0]             readyA;
  logic [NUM_CHANS-1:0][NUM_PORTS-1:0][QOS_W-1:0]  qosA;
  logic [NUM_CHANS-1:0][NUM_PORTS-1:0][ADDR_W-1:0] addrA;
  logic [NUM_CHANS-1:0]                            oValidA;
  logic [NUM_CHANS-1:0]                            oReadyA;
  logic [NUM_CHANS-1:0][ADDR_W-1:0]                oAddrA;
  logic [NUM_CHANS-1:0][QOS_W-1:0]                 oQosA;
  logic [NUM_CHANS-1:0]                            oPortA;

  assign validA  = {wrReqValid, rdReqValid};
  assign qosA    = {wrReqQos, rdReqQos};
  assign addrA   = {wrReqAddr, rdReqAddr};
  assign oReadyA = {wrOutReady, rdOutReady};

  assign rdReqReady = readyA[0];
  assign wrReqReady = readyA[1];
  assign rdOutValid = oValidA[0];
  assign wrOutValid = oValidA[1];
  assign rdOutAddr  = oAddrA[0];
  assign wrOutAddr  = oAddrA[1];
  assign rdOutQos   = oQosA[0];
  assign wrOutQos   = oQosA[1];
  assign rdOutPort  = oPortA[0];
  assign wrOutPort  = oPortA[1];

  // R9: one fully separate control/datapath pair per channel
  for (genvar ch = 0; ch < NUM_CHANS; ch++) begin : g_chan
    arb_strobe_t strb;

    qarb_ctrl #(.QOS_W(QOS_W)) u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .reqValid (validA[ch]),
      .reqQos   (qosA[ch]),
      .outReady (oReadyA[ch]),
      .strb     (strb)
    );

    qarb_datapath #(.QOS_W(QOS_W), .ADDR_W(ADDR_W)) u_dp (
      .clk      (clk),
      .rstN     (rstN),
      .strb     (strb),
      .reqValid (validA[ch]),
      .reqQos   (qosA[ch]),
      .reqAddr  (addrA[ch]),
      .reqReady (readyA[ch]),
      .outValid (oValidA[ch]),
      .outAddr  (oAddrA[ch]),
      .outQos   (oQosA[ch]),
      .outPort  (oPortA[ch])
    );
  end
endmodule

// File: tb/qos_pair_merger_bench.sv
`timescale 1ns/1ps
module qos_pair_merger_bench;
  localparam int AW = 32;
  localparam int RAND_CYCLES = 4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [1:0][1:0]         vIn;
  logic [1:0][1:0][3:0]    qIn;
  logic [1:0][1:0][AW-1:0] aIn;
  logic [1:0]              rdyIn;
  logic [1:0][1:0]         oReady;
  logic [1:0]              oValid;
  logic [1:0]              oPort;
  logic [1:0][3:0]         oQos;
  logic [1:0][AW-1:0]      oAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] mLrg, mHeld, mHeldPort;
  logic [1:0][1:0] acceptedLast;

  qos_pair_merger #(.QOS_W(4), .ADDR_W(AW)) u_qos_pair_merger (
    .clk(clk), .rstN(rstN),
    .rdReqValid(vIn[0]), .rdReqReady(oReady[0]), .rdReqQos(qIn[0]), .rdReqAddr(aIn[0]),
    .rdOutValid(oValid[0]), .rdOutReady(rdyIn[0]), .rdOutAddr(oAddr[0]),
    .rdOutQos(oQos[0]), .rdOutPort(oPort[0]),
    .wrReqValid(vIn[1]), .wrReqReady(oReady[1]), .wrReqQos(qIn[1]), .wrReqAddr(aIn[1]),
    .wrOutValid(oValid[1]), .wrOutReady(rdyIn[1]), .wrOutAddr(oAddr[1]),
    .wrOutQos(oQos[1]), .wrOutPort(oPort[1])
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference grant choice, written from the requirements
  function automatic logic expPick(input int ch);
    logic [1:0] v = vIn[ch];
    if (mHeld[ch] && v[mHeldPort[ch]]) return mHeldPort[ch];
    if (v == 2'b10) return 1'b1;
    if (v == 2'b11) begin
      if (qIn[ch][1] > qIn[ch][0]) return 1'b1;
      if (qIn[ch][0] > qIn[ch][1]) return 1'b0;
      return mLrg[ch];
    end
    return 1'b0;
  endfunction

  task automatic evalCycle();
    #1;
    for (int ch = 0; ch < 2; ch++) begin
      logic [1:0] v = vIn[ch];
      logic sel = expPick(ch);
      logic ev = |v;
      logic fire = ev && rdyIn[ch];
      logic [1:0] er = fire ? (2'b01 << sel) : 2'b00;
      logic [39:0] act, exp;
      string tag;
      if (!ev) tag = "R1";
      else if (mHeld[ch] && v[mHeldPort[ch]]) tag = "R6";
      else if (v != 2'b11) tag = "R5";
      else if (qIn[ch][0] != qIn[ch][1]) tag = "R2";
      else tag = "R3";
      tag = $sformatf("%s/R8 ch%0d", tag, ch);
      exp = {er, ev, sel, qIn[ch][sel], aIn[ch][sel]};
      act = {oReady[ch], oValid[ch], oPort[ch], oQos[ch], oAddr[ch]};
      if (!ev) begin
        exp[36:0] = '0;
        act[36:0] = '0;
      end
      chk(act == exp, tag, 64'(act), 64'(exp));
      if (fire) begin
        mLrg[ch] = ~sel;
        mHeld[ch] = 1'b0;
      end else if (ev) begin
        mHeld[ch] = 1'b1;
        mHeldPort[ch] = sel;
      end else begin
        mHeld[ch] = 1'b0;
      end
      acceptedLast[ch] = er;
    end
  endtask

  task automatic nextCyc();
    @(negedge clk);
  endtask

  task automatic drive(input int ch, input logic [1:0] v, input logic [3:0] q0,
                       input logic [3:0] q1, input logic rdy);
    vIn[ch] = v;
    qIn[ch][0] = q0;
    qIn[ch][1] = q1;
    rdyIn[ch] = rdy;
  endtask

  task automatic freshAddr(input int ch);
    aIn[ch][0] = $urandom;
    aIn[ch][1] = $urandom;
  endtask

  task automatic randDrive(input int ch);
    for (int p = 0; p < 2; p++) begin
      if (vIn[ch][p] && !acceptedLast[ch][p]) continue;
      vIn[ch][p] = ($urandom % 10) < 7;
      qIn[ch][p] = ($urandom % 2) ? 4'($urandom % 4) : 4'($urandom % 16);
      aIn[ch][p] = $urandom;
    end
    rdyIn[ch] = ($urandom % 4) != 0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic prev;
    void'($urandom(32'h5eed_0042));
    vIn = '0; qIn = '0; aIn = '0; rdyIn = '0;
    mLrg = '0; mHeld = '0; mHeldPort = '0; acceptedLast = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: idle after reset
    evalCycle();
    chk(oValid == 2'b00 && oReady == '0, "R1 idle", 64'({oValid, oReady}), 64'd0);
    nextCyc();

    // R1: first tie favours port 0
    drive(0, 2'b11, 4'd5, 4'd5, 1'b1); freshAddr(0);
    evalCycle();
    chk(oPort[0] == 1'b0, "R1 first tie", 64'(oPort[0]), 64'd0);
    nextCyc();

    // R4: continuous equal-QoS requests alternate
    prev = 1'b0;
    for (int i = 0; i < 6; i++) begin
      drive(0, 2'b11, 4'd9, 4'd9, 1'b1); freshAddr(0);
      evalCycle();
      chk(oPort[0] != prev, "R4 alternation", 64'(oPort[0]), 64'(~prev));
      prev = oPort[0];
      nextCyc();
    end

    // R5: lone requestors, extreme QoS
    drive(0, 2'b10, 4'd0, 4'd0, 1'b1); freshAddr(0);
    evalCycle();
    chk(oValid[0] && oPort[0] == 1'b1, "R5 lone port1 qos0", 64'({oValid[0], oPort[0]}), 64'b11);
    nextCyc();
    drive(0, 2'b01, 4'd15, 4'd0, 1'b1); freshAddr(0);
    evalCycle();
    chk(oValid[0] && oPort[0] == 1'b0, "R5 lone port0 qos15", 64'({oValid[0], oPort[0]}), 64'b10);
    nextCyc();

    // R6: stalled grant held against a higher-QoS newcomer
    drive(0, 2'b01, 4'd1, 4'd0, 1'b0); freshAddr(0);
    evalCycle();
    nextCyc();
    for (int i = 0; i < 2; i++) begin
      drive(0, 2'b11, 4'd1, 4'd15, 1'b0);
      evalCycle();
      chk(oPort[0] == 1'b0 && oReady[0] == 2'b00, "R6 hold", 64'({oPort[0], oReady[0]}), 64'd0);
      nextCyc();
    end
    drive(0, 2'b11, 4'd1, 4'd15, 1'b1);
    evalCycle();
    chk(oReady[0] == 2'b01, "R6 release", 64'(oReady[0]), 64'b01);
    nextCyc();
    drive(0, 2'b10, 4'd1, 4'd15, 1'b1);
    evalCycle();
    nextCyc();
    // now port 1 was served last, so tie order favours port 0
    // R7: stalled then withdrawn grant to port 1 leaves tie order alone
    drive(0, 2'b10, 4'd3, 4'd3, 1'b0); freshAddr(0);
    evalCycle(); nextCyc();
    evalCycle(); nextCyc();
    drive(0, 2'b00, 4'd3, 4'd3, 1'b0);
    evalCycle(); nextCyc();
    drive(0, 2'b11, 4'd3, 4'd3, 1'b1); freshAddr(0);
    evalCycle();
    chk(oPort[0] == 1'b0, "R7 tie order after stall", 64'(oPort[0]), 64'd0);
    nextCyc();
    drive(0, 2'b00, 4'd0, 4'd0, 1'b0);

    // R9: write traffic does not disturb the read tie order
    for (int i = 0; i < 3; i++) begin
      drive(1, 2'b01, 4'd7, 4'd0, 1'b1); freshAddr(1);
      evalCycle(); nextCyc();
    end
    drive(0, 2'b11, 4'd4, 4'd4, 1'b1); freshAddr(0);
    drive(1, 2'b11, 4'd4, 4'd4, 1'b1); freshAddr(1);
    evalCycle();
    chk(oPort[0] == 1'b1 && oPort[1] == 1'b1, "R9 independent channels",
        64'({oPort[0], oPort[1]}), 64'b11);
    nextCyc();

    // Random traffic with held stalled requests, R2 R3 R5 R6 R8
    for (int i = 0; i < RAND_CYCLES; i++) begin
      randDrive(0);
      randDrive(1);
      evalCycle();
      nextCyc();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule